// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Sequencer

This block runs a single DMA channel from a 32-byte transfer descriptor held in memory. A one-cycle start pulse names the descriptor's address. The sequencer reads the descriptor in one bus access and checks that its geometry is consistent. It then copies elements of the configured size: each one is a read at the source address followed by a write of the same bytes at the destination address. After every element, both addresses move by their own signed offsets. Each pass that moves the full inner byte count is one outer iteration, and the outer counter counts the passes down.

When the outer counter runs out there are two cases. A plain descriptor adds its end-of-run adjustments to both addresses, restores the outer count and raises done. A chaining descriptor instead fetches a follow-on descriptor from the address kept in its destination-adjust word and carries on with it if that descriptor's start flag is set. Interrupt pulses mark outer completion and the outer halfway point. Configuration faults and bus error responses stop the channel with a sticky error flag.

Top module: `dma_chan_seq`

Descriptor layout (little-endian, word k at byte 4k):
- Word 0: source address.
- Word 1: signed source step in [15:0], source size code in [18:16], destination size code in [22:20].
- Word 2: inner byte count.
- Word 3: source end adjustment.
- Word 4: destination address.
- Word 5: signed destination step in [15:0], current outer count in [24:16].
- Word 6: destination end adjustment, or the next descriptor address when chaining.
- Word 7: initial outer count in [8:0], start flag [16], completion interrupt enable [17], halfway interrupt enable [18], chain enable [19]. Other bits are ignored.

## Requirements
- R1: After reset the block is idle with busy, done, irq, all error flags and memReq low. A start pulse while idle causes one read of size code 5 (32 bytes) at descAddr, and the fields are taken from it in the layout above.
- R2: Size code c moves 2^c bytes per element. Codes 0, 1, 2, 4 and 5 (1, 2, 4, 16, 32 bytes) are legal. Each element is a read of that size at the source address, then a write of the same bytes (upper lanes zero) at the destination address.
- R3: After each element write, the source address gains the sign-extended source step and the destination address gains the sign-extended destination step. An inner loop ends once the inner byte count has been moved.
- R4: The outer count drops by one at the end of each inner loop. Outer completion is the end of the inner loop that takes it to zero.
- R5: At outer completion without chaining, both end adjustments are added (on top of the last step), the outer count is reloaded from the initial count, done is set and busy falls.
- R6: At outer completion with the completion interrupt enable set, irq is high for exactly one cycle.
- R7: With the halfway enable set, irq pulses for one cycle when a decrement leaves a nonzero count equal to the initial count shifted right by one.
- R8: At outer completion with chaining enabled, no adjustment is applied and the next descriptor is read from word 6. If its start flag is set it runs; if clear the channel stops idle with done set, showing the loaded fields.
- R9: A descriptor with an illegal or unequal source and destination size code, a zero or non-multiple inner byte count, a misaligned source or destination address, or a zero current outer count sets errCfg and makes no data access.
- R10: A memErr response aborts the channel: on a descriptor or source read it sets errSrc, on a destination write it sets errDst. No further access follows and done stays low.
- R11: A start pulse while busy is ignored. A start pulse while idle clears done and all error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle request to load and run a descriptor |
| descAddr | input | 32 | Address of the descriptor to load |
| memReq | output | 1 | Memory access request, held until a response |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 32 | Byte address of the access |
| memSize | output | 3 | Access size code (bytes = 2^code) |
| memWdata | output | 256 | Write data, element in the low bytes |
| memRdata | input | 256 | Read data, element in the low bytes |
| memAck | input | 1 | One-cycle success response |
| memErr | input | 1 | One-cycle error response |
| busy | output | 1 | Channel active |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle interrupt pulse |
| errCfg | output | 1 | Sticky configuration error |
| errSrc | output | 1 | Sticky descriptor or source read error |
| errDst | output | 1 | Sticky destination write error |
| srcAddr | output | 32 | Current source address |
| dstAddr | output | 32 | Current destination address |
| majorCount | output | 9 | Current outer count |

## Verification
The bench builds the block at its defaults: a 9-bit outer count, 16-bit signed steps and a 32-byte bus. The full bus width lets every legal size code run, up to 32-byte elements and the single-access descriptor fetch. Small outer counts of one to four are enough to reach the halfway pulse, the case where an initial count of one has no halfway point, and end adjustments with both negative and positive steps. Chained runs cover a follow-on descriptor with its start flag set and one with it clear. The bench also injects error responses on a source read and on a destination write.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  localparam int WORD_W = 32;
  localparam int DESC_BYTES = 32;
  localparam logic [2:0] DESC_SIZE_CODE = 3'd5;

  typedef enum logic [1:0] {
    SEL_DESC = 2'd0,
    SEL_SRC  = 2'd1,
    SEL_DST  = 2'd2
  } memSel_e;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_FETCH = 3'd1,
    S_CHECK = 3'd2,
    S_READ  = 3'd3,
    S_WRITE = 3'd4
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    memSel_e memSel;
    logic    capturePtr;
    logic    chainPtr;
    logic    loadDesc;
    logic    initMinor;
    logic    latchData;
    logic    step;
    logic    lastElem;
    logic    finalAdj;
  } dpStrobe_t;

  function automatic logic sizeCodeOk(input logic [2:0] code);
    case (code)
      3'd0, 3'd1, 3'd2, 3'd4, 3'd5: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/dma_seq_dpath.sv
module dma_seq_dpath
  import dma_seq_pkg::*;
#(
  parameter int MAJOR_W = 9,
  parameter int OFF_W = 16,
  parameter int BUS_BYTES = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                stb,
  input  logic [WORD_W-1:0]        descAddr,
  input  logic [BUS_BYTES*8-1:0]   memRdata,
  output logic [WORD_W-1:0]        memAddr,
  output logic [2:0]               memSize,
  output logic [BUS_BYTES*8-1:0]   memWdata,
  output logic                     cfgOk,
  output logic                     startBit,
  output logic                     sgEn,
  output logic                     intMajEn,
  output logic                     intHalfEn,
  output logic                     lastElem,
  output logic                     majorIsOne,
  output logic                     halfHit,
  output logic [WORD_W-1:0]        srcAddr,
  output logic [WORD_W-1:0]        dstAddr,
  output logic [MAJOR_W-1:0]       majorCount
);
  localparam int BUS_W = BUS_BYTES * 8;
  localparam int W1 = 1 * WORD_W;
  localparam int W2 = 2 * WORD_W;
  localparam int W3 = 3 * WORD_W;
  localparam int W4 = 4 * WORD_W;
  localparam int W5 = 5 * WORD_W;
  localparam int W6 = 6 * WORD_W;
  localparam int W7 = 7 * WORD_W;

  logic [WORD_W-1:0]  ptrQ, srcQ, dstQ, slastQ, dlastQ, minorQ, remQ;
  logic [OFF_W-1:0]   soffQ, doffQ;
  logic [MAJOR_W-1:0] curQ, begQ;
  logic [2:0]         ssizeQ, dsizeQ;
  logic               startQ, intMajQ, intHalfQ, sgQ;
  logic [BUS_W-1:0]   dataQ;

  logic [WORD_W-1:0]  elemBytes, alignMask, soffExt, doffExt;
  logic [WORD_W-1:0]  srcAdj, dstAdj;
  logic [BUS_W-1:0]   laneMask;
  logic [MAJOR_W-1:0] curLess;

  assign elemBytes = WORD_W'(1) << ssizeQ;
  assign alignMask = elemBytes - WORD_W'(1);
  assign soffExt   = {{(WORD_W-OFF_W){soffQ[OFF_W-1]}}, soffQ};
  assign doffExt   = {{(WORD_W-OFF_W){doffQ[OFF_W-1]}}, doffQ};
  assign srcAdj    = stb.finalAdj ? slastQ : '0;
  assign dstAdj    = stb.finalAdj ? dlastQ : '0;
  assign curLess   = curQ - MAJOR_W'(1);

  generate
    for (genvar b = 0; b < BUS_BYTES; b++) begin : g_lane
      assign laneMask[8*b +: 8] = (WORD_W'(b) < elemBytes) ? 8'hFF : 8'h00;
    end
  endgenerate

  always_comb begin
    cfgOk = sizeCodeOk(ssizeQ) && (ssizeQ == dsizeQ) && (minorQ != '0) &&
            ((minorQ & alignMask) == '0) && ((srcQ & alignMask) == '0) &&
            ((dstQ & alignMask) == '0) && (curQ != '0);
  end

  assign lastElem   = (remQ == elemBytes);
  assign majorIsOne = (curQ == MAJOR_W'(1));
  assign halfHit    = (curQ != MAJOR_W'(1)) && (curLess == (begQ >> 1));
  assign startBit   = startQ;
  assign sgEn       = sgQ;
  assign intMajEn   = intMajQ;
  assign intHalfEn  = intHalfQ;
  assign srcAddr    = srcQ;
  assign dstAddr    = dstQ;
  assign majorCount = curQ;
  assign memWdata   = dataQ;

  always_comb begin
    case (stb.memSel)
      SEL_SRC: memAddr = srcQ;
      SEL_DST: memAddr = dstQ;
      default: memAddr = ptrQ;
    endcase
    memSize = (stb.memSel == SEL_DESC) ? DESC_SIZE_CODE : ssizeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0; srcQ <= '0; dstQ <= '0; slastQ <= '0; dlastQ <= '0;
      minorQ <= '0; remQ <= '0; soffQ <= '0; doffQ <= '0;
      curQ <= '0; begQ <= '0; ssizeQ <= '0; dsizeQ <= '0;
      startQ <= 1'b0; intMajQ <= 1'b0; intHalfQ <= 1'b0; sgQ <= 1'b0;
      dataQ <= '0;
    end else begin
      if (stb.capturePtr) ptrQ <= descAddr;
      else if (stb.chainPtr) ptrQ <= dlastQ;

      if (stb.loadDesc) begin
        srcQ     <= memRdata[0 +: WORD_W];
        soffQ    <= memRdata[W1 +: OFF_W];
        ssizeQ   <= memRdata[W1+16 +: 3];
        dsizeQ   <= memRdata[W1+20 +: 3];
        minorQ   <= memRdata[W2 +: WORD_W];
        slastQ   <= memRdata[W3 +: WORD_W];
        dstQ     <= memRdata[W4 +: WORD_W];
        doffQ    <= memRdata[W5 +: OFF_W];
        curQ     <= memRdata[W5+16 +: MAJOR_W];
        dlastQ   <= memRdata[W6 +: WORD_W];
        begQ     <= memRdata[W7 +: MAJOR_W];
        startQ   <= memRdata[W7+16];
        intMajQ  <= memRdata[W7+17];
        intHalfQ <= memRdata[W7+18];
        sgQ      <= memRdata[W7+19];
      end else if (stb.step) begin
        srcQ <= srcQ + soffExt + srcAdj;
        dstQ <= dstQ + doffExt + dstAdj;
        if (stb.lastElem) curQ <= stb.finalAdj ? begQ : curLess;
      end

      if (stb.initMinor) remQ <= minorQ;
      else if (stb.step) remQ <= remQ - elemBytes;

      if (stb.latchData) dataQ <= memRdata & laneMask;
    end
  end

  // R3
  rem_cover_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |-> (remQ >= elemBytes));

  // R4
  major_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |-> (curQ != '0));
endmodule

// File: rtl/dma_seq_ctrl.sv
module dma_seq_ctrl
  import dma_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  logic      memAck,
  input  logic      memErr,
  input  logic      cfgOk,
  input  logic      startBit,
  input  logic      sgEn,
  input  logic      intMajEn,
  input  logic      intHalfEn,
  input  logic      lastElem,
  input  logic      majorIsOne,
  input  logic      halfHit,
  output dpStrobe_t stb,
  output logic      memReq,
  output logic      memWe,
  output logic      busy,
  output logic      done,
  output logic      irq,
  output logic      errCfg,
  output logic      errSrc,
  output logic      errDst
);
  seqState_e stateQ, stateD;
  logic chainedQ, chainedD;
  logic doneQ, doneD, irqQ, irqD;
  logic errCfgQ, errCfgD, errSrcQ, errSrcD, errDstQ, errDstD;

  always_comb begin
    stateD   = stateQ;
    chainedD = chainedQ;
    doneD    = doneQ;
    irqD     = 1'b0;
    errCfgD  = errCfgQ;
    errSrcD  = errSrcQ;
    errDstD  = errDstQ;
    stb      = '0;
    stb.memSel = SEL_DESC;
    case (stateQ)
      S_IDLE: begin
        if (startPulse) begin
          stb.capturePtr = 1'b1;
          chainedD = 1'b0;
          doneD = 1'b0;
          errCfgD = 1'b0;
          errSrcD = 1'b0;
          errDstD = 1'b0;
          stateD = S_FETCH;
        end
      end
      S_FETCH: begin
        if (memErr) begin
          errSrcD = 1'b1;
          stateD = S_IDLE;
        end else if (memAck) begin
          stb.loadDesc = 1'b1;
          stateD = S_CHECK;
        end
      end
      S_CHECK: begin
        if (chainedQ && !startBit) begin
          doneD = 1'b1;
          stateD = S_IDLE;
        end else if (!cfgOk) begin
          errCfgD = 1'b1;
          stateD = S_IDLE;
        end else begin
          stb.initMinor = 1'b1;
          stateD = S_READ;
        end
      end
      S_READ: begin
        stb.memSel = SEL_SRC;
        if (memErr) begin
          errSrcD = 1'b1;
          stateD = S_IDLE;
        end else if (memAck) begin
          stb.latchData = 1'b1;
          stateD = S_WRITE;
        end
      end
      S_WRITE: begin
        stb.memSel = SEL_DST;
        if (memErr) begin
          errDstD = 1'b1;
          stateD = S_IDLE;
        end else if (memAck) begin
          stb.step = 1'b1;
          stateD = S_READ;
          if (lastElem) begin
            stb.lastElem = 1'b1;
            stb.initMinor = 1'b1;
            if (majorIsOne) begin
              irqD = intMajEn;
              if (sgEn) begin
                stb.chainPtr = 1'b1;
                chainedD = 1'b1;
                stateD = S_FETCH;
              end else begin
                stb.finalAdj = 1'b1;
                doneD = 1'b1;
                stateD = S_IDLE;
              end
            end else begin
              irqD = intHalfEn && halfHit;
            end
          end
        end
      end
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      chainedQ <= 1'b0;
      doneQ <= 1'b0;
      irqQ <= 1'b0;
      errCfgQ <= 1'b0;
      errSrcQ <= 1'b0;
      errDstQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      chainedQ <= chainedD;
      doneQ <= doneD;
      irqQ <= irqD;
      errCfgQ <= errCfgD;
      errSrcQ <= errSrcD;
      errDstQ <= errDstD;
    end
  end

  assign memReq = (stateQ == S_FETCH) || (stateQ == S_READ) || (stateQ == S_WRITE);
  assign memWe  = (stateQ == S_WRITE);
  assign busy   = (stateQ != S_IDLE);
  assign done   = doneQ;
  assign irq    = irqQ;
  assign errCfg = errCfgQ;
  assign errSrc = errSrcQ;
  assign errDst = errDstQ;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck && !memErr) |=> (memReq && $stable(memWe) && $stable(stb.memSel)));

  // R10
  err_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errCfgQ, errSrcQ, errDstQ}));

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> !busy);

  // R9
  cfg_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errCfgQ) |-> !memReq);

  // R6
  irq_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> $past(memWe && memAck));
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int MAJOR_W = 9,
  parameter int OFF_W = 16,
  parameter int BUS_BYTES = DESC_BYTES
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   startPulse,
  input  logic [31:0]            descAddr,
  output logic                   memReq,
  output logic                   memWe,
  output logic [31:0]            memAddr,
  output logic [2:0]             memSize,
  output logic [BUS_BYTES*8-1:0] memWdata,
  input  logic [BUS_BYTES*8-1:0] memRdata,
  input  logic                   memAck,
  input  logic                   memErr,
  output logic                   busy,
  output logic                   done,
  output logic                   irq,
  output logic                   errCfg,
  output logic                   errSrc,
  output logic                   errDst,
  output logic [31:0]            srcAddr,
  output logic [31:0]            dstAddr,
  output logic [MAJOR_W-1:0]     majorCount
);
  dpStrobe_t stb;
  logic cfgOk, startBit, sgEn, intMajEn, intHalfEn, lastElem, majorIsOne, halfHit;

  dma_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse),
    .memAck(memAck), .memErr(memErr),
    .cfgOk(cfgOk), .startBit(startBit), .sgEn(sgEn),
    .intMajEn(intMajEn), .intHalfEn(intHalfEn),
    .lastElem(lastElem), .majorIsOne(majorIsOne), .halfHit(halfHit),
    .stb(stb), .memReq(memReq), .memWe(memWe), .busy(busy),
    .done(done), .irq(irq), .errCfg(errCfg), .errSrc(errSrc), .errDst(errDst)
  );

  dma_seq_dpath #(.MAJOR_W(MAJOR_W), .OFF_W(OFF_W), .BUS_BYTES(BUS_BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .descAddr(descAddr), .memRdata(memRdata),
    .memAddr(memAddr), .memSize(memSize), .memWdata(memWdata),
    .cfgOk(cfgOk), .startBit(startBit), .sgEn(sgEn),
    .intMajEn(intMajEn), .intHalfEn(intHalfEn),
    .lastElem(lastElem), .majorIsOne(majorIsOne), .halfHit(halfHit),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .majorCount(majorCount)
  );
endmodule

// File: tb/dma_chan_seq_test.sv
module dma_chan_seq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [31:0] descAddr = '0;
  logic memReq, memWe;
  logic [31:0] memAddr;
  logic [2:0] memSize;
  logic [255:0] memWdata;
  logic [255:0] memRdata = '0;
  logic memAck = 1'b0;
  logic memErr = 1'b0;
  logic busy, done, irq, errCfg, errSrc, errDst;
  logic [31:0] srcAddr, dstAddr;
  logic [8:0] majorCount;

  always #10 clk = ~clk;

  dma_chan_seq uut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .descAddr(descAddr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memSize(memSize),
    .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck), .memErr(memErr),
    .busy(busy), .done(done), .irq(irq), .errCfg(errCfg), .errSrc(errSrc),
    .errDst(errDst), .srcAddr(srcAddr), .dstAddr(dstAddr), .majorCount(majorCount)
  );

  typedef struct {
    int unsigned src, dst, minor;
    int soff, doff, slast, dlast, cur, beg, ssize, dsize;
    bit start, intMaj, intHalf, sg;
  } desc_t;

  typedef struct packed {
    logic [31:0] a;
    logic [2:0] sz;
    logic [255:0] d;
  } wr_t;

  logic [7:0] mem [int unsigned];
  wr_t expQ[$];
  int nVec = 0, nFail = 0, irqCount = 0, wrCount = 0, fetchCount = 0, cycles = 0;
  logic [31:0] errAddr = 32'hFFFF_FFF0;

  function automatic logic [7:0] patByte(input int unsigned a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] rdByte(input int unsigned a);
    if (mem.exists(a)) return mem[a];
    return patByte(a);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // memory model and write monitor (scoreboard consumer)
  int nbM;
  logic [255:0] rdV;
  wr_t gotW, expW;
  always @(posedge clk) begin
    memAck <= 1'b0;
    memErr <= 1'b0;
    if (rstN && memReq && !memAck && !memErr) begin
      nbM = 1 << memSize;
      if (memAddr == errAddr) memErr <= 1'b1;
      else begin
        if (memWe) begin
          for (int b = 0; b < nbM; b++) mem[memAddr + b] = memWdata[8*b +: 8];
          wrCount++;
          gotW = '{a: memAddr, sz: memSize, d: memWdata};
          nVec++;
          if (expQ.size() == 0) begin
            nFail++;
            $display("FAIL R2 unexpected write: got addr %h size %0d expected none", memAddr, memSize);
          end else begin
            expW = expQ.pop_front();
            if (gotW !== expW) begin
              nFail++;
              $display("FAIL R2/R3 write: got addr %h size %0d data %h expected addr %h size %0d data %h",
                       gotW.a, gotW.sz, gotW.d, expW.a, expW.sz, expW.d);
            end
          end
        end else begin
          rdV = '0;
          for (int b = 0; b < nbM; b++) rdV[8*b +: 8] = rdByte(memAddr + b);
          memRdata <= rdV;
          if (memAddr >= 32'h1000 && memAddr < 32'h2000) begin
            fetchCount++;
            // R1
            if (memSize != 3'd5) begin
              nFail++;
              $display("FAIL R1 fetch size: got %0d expected 5", memSize);
            end
          end
        end
        memAck <= 1'b1;
      end
    end
  end

  always @(negedge clk) if (irq) irqCount++;

  always @(negedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  function automatic desc_t mk(input int unsigned s, input int unsigned d, input int code,
                               input int so, input int dof, input int unsigned mn, input int c);
    desc_t r;
    r.src = s; r.dst = d; r.minor = mn; r.soff = so; r.doff = dof;
    r.slast = 0; r.dlast = 0; r.cur = c; r.beg = c; r.ssize = code; r.dsize = code;
    r.start = 1'b1; r.intMaj = 1'b0; r.intHalf = 1'b0; r.sg = 1'b0;
    return r;
  endfunction

  task automatic putDesc(input int unsigned a, input desc_t d);
    logic [255:0] v;
    v = '0;
    v[31:0] = d.src; v[47:32] = d.soff[15:0]; v[50:48] = d.ssize[2:0]; v[54:52] = d.dsize[2:0];
    v[95:64] = d.minor; v[127:96] = d.slast; v[159:128] = d.dst;
    v[175:160] = d.doff[15:0]; v[184:176] = d.cur[8:0]; v[223:192] = d.dlast;
    v[232:224] = d.beg[8:0]; v[240] = d.start; v[241] = d.intMaj; v[242] = d.intHalf; v[243] = d.sg;
    for (int b = 0; b < 32; b++) mem[a + b] = v[8*b +: 8];
  endtask

  // scoreboard producer: predicts writes, final state and interrupts
  task automatic model(input desc_t d, input int maxW, output int unsigned sF,
                       output int unsigned dF, output int cF, output int irqs);
    int unsigned s, t;
    int c, nb, n;
    logic [255:0] v;
    s = d.src; t = d.dst; c = d.cur; nb = 1 << d.ssize; n = 0; irqs = 0;
    forever begin
      for (int e = 0; e < int'(d.minor) / nb; e++) begin
        if (n < maxW) begin
          v = '0;
          for (int b = 0; b < nb; b++) v[8*b +: 8] = rdByte(s + b);
          expQ.push_back('{a: t, sz: d.ssize[2:0], d: v});
        end
        n++;
        s = s + d.soff; t = t + d.doff;
      end
      c--;
      if (c == 0) begin
        if (!d.sg) begin s = s + d.slast; t = t + d.dlast; c = d.beg; end
        if (d.intMaj) irqs++;
        break;
      end else if (d.intHalf && c == d.beg / 2) irqs++;
    end
    sF = s; dF = t; cF = c;
  endtask

  task automatic launch(input int unsigned a);
    irqCount = 0; wrCount = 0; fetchCount = 0;
    @(negedge clk);
    descAddr = a; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic runGood(input string tag, input int unsigned a, input desc_t d);
    int unsigned sF, dF; int cF, irqs;
    putDesc(a, d);
    model(d, 1 << 20, sF, dF, cF, irqs);
    launch(a);
    chk({tag, " all writes seen"}, expQ.size(), 0);
    chk({tag, " R5 done"}, {31'd0, done}, 1);
    chk({tag, " R5 busy"}, {31'd0, busy}, 0);
    chk({tag, " R3 R5 src"}, srcAddr, sF);
    chk({tag, " R3 R5 dst"}, dstAddr, dF);
    chk({tag, " R4 R5 count"}, {23'd0, majorCount}, cF);
    chk({tag, " R6 R7 irqs"}, irqCount, irqs);
    chk({tag, " R11 errs"}, {29'd0, errCfg, errSrc, errDst}, 0);
  endtask

  task automatic runCfgErr(input string tag, input int unsigned a, input desc_t d);
    putDesc(a, d);
    launch(a);
    chk({tag, " R9 errCfg"}, {31'd0, errCfg}, 1);
    chk({tag, " R9 no access"}, wrCount, 0);
    chk({tag, " R9 done low"}, {31'd0, done}, 0);
  endtask

  initial begin
    desc_t d, d2;
    int unsigned sF, dF; int cF, irqs;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset idle", {26'd0, busy, done, irq, errCfg, errSrc, errDst}, 0);
    chk("R1 reset memReq", {31'd0, memReq}, 0);

    // R2 R3 R6: 4-byte elements, wrap-around end adjustment
    d = mk(32'h4000, 32'h8000, 2, 4, 4, 8, 3);
    d.slast = -24; d.dlast = -24; d.intMaj = 1'b1;
    runGood("T1 R1 R2", 32'h1000, d);
    chk("T1 R1 one fetch", fetchCount, 1);

    // R3 R7: byte elements, negative source step, halfway pulse only
    d = mk(32'h4100, 32'h8100, 0, -1, 2, 3, 4);
    d.slast = 5; d.intHalf = 1'b1;
    runGood("T2 R7", 32'h1020, d);

    // R2 R7: 32-byte elements, initial count 1 has no halfway point
    d = mk(32'h4200, 32'h8200, 5, 32, 32, 64, 1);
    d.intMaj = 1'b1; d.intHalf = 1'b1;
    runGood("T3 R2 R7", 32'h1040, d);

    // R2 R7: 16-byte elements, negative destination step
    d = mk(32'h4300, 32'h8340, 4, 16, -16, 16, 2);
    d.intHalf = 1'b1;
    runGood("T4 R2", 32'h1060, d);

    // R2: 2-byte elements
    d = mk(32'h4402, 32'h8402, 1, 2, 2, 6, 1);
    runGood("T5 R2", 32'h1080, d);

    // R8: chain into a started descriptor
    d = mk(32'h4500, 32'h8500, 2, 4, 4, 8, 1);
    d.sg = 1'b1; d.dlast = 32'h1120; d.intMaj = 1'b1;
    d2 = mk(32'h4600, 32'h8600, 0, 1, 1, 2, 2);
    d2.slast = -4; d2.dlast = -4; d2.intMaj = 1'b1;
    putDesc(32'h1100, d); putDesc(32'h1120, d2);
    model(d, 1 << 20, sF, dF, cF, irqs);
    model(d2, 1 << 20, sF, dF, cF, irqs);
    launch(32'h1100);
    chk("T6 R8 writes", expQ.size(), 0);
    chk("T6 R8 fetches", fetchCount, 2);
    chk("T6 R8 irqs", irqCount, 2);
    chk("T6 R8 src", srcAddr, 32'h4600);
    chk("T6 R8 dst", dstAddr, 32'h8600);
    chk("T6 R8 count", {23'd0, majorCount}, 2);
    chk("T6 R8 done", {31'd0, done}, 1);

    // R8: chain into a descriptor whose start flag is clear
    d = mk(32'h4900, 32'h8900, 0, 1, 1, 1, 1);
    d.sg = 1'b1; d.dlast = 32'h1160;
    d2 = mk(32'h4777, 32'h8777, 3, 1, 1, 7, 5);
    d2.start = 1'b0;
    putDesc(32'h1140, d); putDesc(32'h1160, d2);
    model(d, 1 << 20, sF, dF, cF, irqs);
    launch(32'h1140);
    chk("T7 R8 writes", wrCount, 1);
    chk("T7 R8 sb empty", expQ.size(), 0);
    chk("T7 R8 done", {31'd0, done}, 1);
    chk("T7 R8 busy", {31'd0, busy}, 0);
    chk("T7 R8 loaded src", srcAddr, 32'h4777);
    chk("T7 R8 loaded count", {23'd0, majorCount}, 5);

    // R9 configuration faults
    d = mk(32'h4000, 32'h8000, 3, 8, 8, 8, 1);
    runCfgErr("E1 size code 3", 32'h1180, d);
    d = mk(32'h4000, 32'h8000, 2, 4, 4, 6, 1);
    runCfgErr("E2 count", 32'h11A0, d);
    d = mk(32'h4002, 32'h8000, 2, 4, 4, 8, 1);
    runCfgErr("E3 align", 32'h11C0, d);
    d = mk(32'h4000, 32'h8000, 2, 4, 4, 8, 1);
    d.dsize = 1;
    runCfgErr("E4 mismatch", 32'h11E0, d);
    d = mk(32'h4000, 32'h8000, 2, 4, 4, 8, 0);
    runCfgErr("E5 zero count", 32'h1200, d);

    // R10 source error on the second element
    d = mk(32'h4800, 32'h8800, 2, 4, 4, 8, 1);
    putDesc(32'h1220, d);
    model(d, 1, sF, dF, cF, irqs);
    errAddr = 32'h4804;
    launch(32'h1220);
    errAddr = 32'hFFFF_FFF0;
    chk("M1 R10 errSrc", {29'd0, errCfg, errSrc, errDst}, 3'b010);
    chk("M1 R10 writes", wrCount, 1);
    chk("M1 R10 sb empty", expQ.size(), 0);
    chk("M1 R10 done", {30'd0, done, busy}, 0);

    // R10 destination error on the first write
    d = mk(32'h4a00, 32'h8a00, 2, 4, 4, 8, 1);
    putDesc(32'h1240, d);
    errAddr = 32'h8a00;
    launch(32'h1240);
    errAddr = 32'hFFFF_FFF0;
    chk("M2 R10 errDst", {29'd0, errCfg, errSrc, errDst}, 3'b001);
    chk("M2 R10 writes", wrCount, 0);
    chk("M2 R10 done", {31'd0, done}, 0);

    // R11: start clears errors; extra start while busy ignored
    d = mk(32'h4b00, 32'h8b00, 2, 4, 4, 8, 2);
    d.slast = -16; d.dlast = -16;
    putDesc(32'h1260, d);
    d2 = mk(32'h4c00, 32'h8c00, 0, 1, 1, 4, 1);
    putDesc(32'h1280, d2);
    model(d, 1 << 20, sF, dF, cF, irqs);
    irqCount = 0; wrCount = 0; fetchCount = 0;
    @(negedge clk); descAddr = 32'h1260; startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    chk("S1 R11 errs cleared", {29'd0, errCfg, errSrc, errDst}, 0);
    repeat (4) @(negedge clk);
    descAddr = 32'h1280; startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    chk("S1 R11 one fetch", fetchCount, 1);
    chk("S1 R11 sb empty", expQ.size(), 0);
    chk("S1 R11 writes", wrCount, 4);
    chk("S1 R11 src", srcAddr, 32'h4b00);
    chk("S1 R11 done", {31'd0, done}, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule